// File: doc/BRIEF.md
# Pipeline Hazard Control Unit

This block is the purely combinational hazard controller for a five-stage in-order pipeline with fetch, decode/read, execute, memory and write-back stages. It looks at the two source register numbers of the instruction that the decode/execute register holds. It also looks at the destination number, the write flag and the load flag of the instruction in the execute/memory register, and at the destination number and write flag of the instruction in the memory/write-back register. From these it decides where each ALU operand comes from and drives two 3:1 operand multiplexers itself. The two operand outputs feed the ALU directly.

The same block also produces the enables and clears for the pipeline registers and a one-bit PC source select. A load whose result is needed by the very next instruction freezes the front of the pipeline for one cycle and puts a bubble into the execute/memory register. A jump or taken branch that is resolved in execute steers the PC to the ALU-computed target and clears the two younger, wrong-path instructions. When no hazard is active, the enable and clear values supplied from outside (for example by a single-step controller) pass through unchanged. All pins are plain level signals with no handshake, because the block decides within the cycle and holds no state.

Top module: `hz_ctrl_unit`

## Requirements
- R1: Each operand select is 2 bits: code 2 picks the execute/memory ALU result, code 1 picks the memory/write-back data, code 0 picks the register-file value. Code 3 never appears. The operand output always equals the source that its select names.
- R2: When an operand's source register matches the execute/memory destination and that stage's write flag is set, the select is 2.
- R3: When the execute/memory stage does not qualify but the memory/write-back destination matches with its write flag set, the select is 1.
- R4: When both stages qualify, the execute/memory stage wins. Writes of 3 (older) and 4 (younger) to one register, followed by a self-add, give operands summing to 8.
- R5: When neither stage qualifies, including a match whose write flag is clear, the select is 0 and the register-file value is passed on.
- R6: Register number 0 never causes forwarding or a stall.
- R7: The two operands are resolved independently, each by its own source register number.
- R8: A load-use stall occurs when the execute/memory stage has both its write flag and its load flag set and its destination matches either source register. During the stall the PC, IF/DR and DR/EX enables are 0 and the EX/MEM clear is 1. Once the load has advanced one stage the stall drops, so exactly one bubble is added.
- R9: Without a stall, the PC enable follows the default enable input, the EX/MEM clear follows the default clear input, and the IF/DR and DR/EX enables are 1. A non-load producer never stalls.
- R10: A redirect request from execute sets the PC select to 1 (take the ALU target) and drives the IF/DR and DR/EX clears to 1.
- R11: Without a redirect, the PC select is 0 (sequential PC) and the IF/DR and DR/EX clears follow the default clear input.
- R12: While a stall is active, a redirect request is ignored: the PC select is 0 and the IF/DR and DR/EX clears follow the default clear input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src0_reg | input | REG_ADDR_W | Source register A of the instruction in DR/EX |
| ex_src1_reg | input | REG_ADDR_W | Source register B of the instruction in DR/EX |
| ex_src0_rf | input | DATA_W | Register-file value read for source A |
| ex_src1_rf | input | DATA_W | Register-file value read for source B |
| mem_dst_reg | input | REG_ADDR_W | Destination register held in EX/MEM |
| mem_wr | input | 1 | EX/MEM instruction writes a register |
| mem_is_load | input | 1 | EX/MEM instruction is a memory load |
| mem_alu_res | input | DATA_W | ALU result held in EX/MEM |
| wb_dst_reg | input | REG_ADDR_W | Destination register held in MEM/WB |
| wb_wr | input | 1 | MEM/WB instruction writes a register |
| wb_data | input | DATA_W | Result data held in MEM/WB |
| ex_redirect | input | 1 | Jump or taken branch resolved in execute |
| dflt_en | input | 1 | Default PC enable when no hazard |
| dflt_clr | input | 1 | Default register clear when no hazard |
| fwd_sel0 | output | 2 | Forwarding select for operand A |
| fwd_sel1 | output | 2 | Forwarding select for operand B |
| alu_opa | output | DATA_W | Selected operand A |
| alu_opb | output | DATA_W | Selected operand B |
| pc_en | output | 1 | PC load enable |
| ifdr_en | output | 1 | IF/DR register enable |
| drex_en | output | 1 | DR/EX register enable |
| ifdr_clr | output | 1 | IF/DR clear (bubble) |
| drex_clr | output | 1 | DR/EX clear (bubble) |
| exmem_clr | output | 1 | EX/MEM clear (bubble) |
| pc_sel | output | 1 | 1 = load PC from ALU target, 0 = PC plus 4 |

## Verification
The bench builds the block with the default 5-bit register numbers and 32-bit data. The 5-bit numbers allow matches on the highest register, 31, as well as the zero register. The 32-bit data allows operand values that are different enough to show which of the three sources reached the ALU. At each step the bench moves the register numbers stage by stage, as a pipeline would, through a producer/consumer pair, a load followed by a dependent use, and a taken jump. It counts stall cycles and flushed slots against the counts that the requirements call for.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    FWD_RF  = 2'd0,
    FWD_WB  = 2'd1,
    FWD_MEM = 2'd2
  } fwd_sel_e;
endpackage

// File: rtl/hz_fwd_select.sv
module hz_fwd_select
  import hz_pkg::*;
#(
  parameter int REG_ADDR_W = 5
) (
  input  logic [REG_ADDR_W-1:0] src_reg,
  input  logic [REG_ADDR_W-1:0] mem_dst_reg,
  input  logic                  mem_wr,
  input  logic [REG_ADDR_W-1:0] wb_dst_reg,
  input  logic                  wb_wr,
  output fwd_sel_e              sel
);
  localparam logic [REG_ADDR_W-1:0] ZERO_REG = '0;

  logic src_live, hit_mem, hit_wb;

  assign src_live = (src_reg != ZERO_REG);
  assign hit_mem  = src_live && mem_wr && (src_reg == mem_dst_reg);
  assign hit_wb   = src_live && wb_wr  && (src_reg == wb_dst_reg);

  // nearer producer checked first: it holds the younger value
  always_comb begin
    if (hit_mem)     sel = FWD_MEM;
    else if (hit_wb) sel = FWD_WB;
    else             sel = FWD_RF;
  end
endmodule

// File: rtl/hz_operand_mux.sv
module hz_operand_mux
  import hz_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  fwd_sel_e          sel,
  input  logic [DATA_W-1:0] rf_val,
  input  logic [DATA_W-1:0] mem_val,
  input  logic [DATA_W-1:0] wb_val,
  output logic [DATA_W-1:0] op
);
  always_comb begin
    unique case (sel)
      FWD_MEM: op = mem_val;
      FWD_WB:  op = wb_val;
      default: op = rf_val;
    endcase
  end
endmodule

// File: rtl/hz_load_stall.sv
module hz_load_stall #(
  parameter int REG_ADDR_W = 5,
  parameter int NUM_SRC    = 2
) (
  input  logic [NUM_SRC-1:0][REG_ADDR_W-1:0] src_regs,
  input  logic [REG_ADDR_W-1:0]              mem_dst_reg,
  input  logic                               mem_wr,
  input  logic                               mem_is_load,
  output logic                               stall
);
  localparam logic [REG_ADDR_W-1:0] ZERO_REG = '0;

  logic [NUM_SRC-1:0] src_hit;
  logic               load_live;

  assign load_live = mem_wr && mem_is_load && (mem_dst_reg != ZERO_REG);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign src_hit[g] = (src_regs[g] == mem_dst_reg);
  end

  assign stall = load_live && (|src_hit);
endmodule

// File: rtl/hz_flow_ctrl.sv
module hz_flow_ctrl (
  input  logic stall,
  input  logic redirect_req,
  input  logic dflt_en,
  input  logic dflt_clr,
  output logic pc_en,
  output logic ifdr_en,
  output logic drex_en,
  output logic ifdr_clr,
  output logic drex_clr,
  output logic exmem_clr,
  output logic pc_sel
);
  logic redirect_take;

  // a held instruction in DR/EX must not be flushed before it resolves
  assign redirect_take = redirect_req && !stall;

  always_comb begin
    pc_en     = stall ? 1'b0 : dflt_en;
    ifdr_en   = !stall;
    drex_en   = !stall;
    exmem_clr = stall ? 1'b1 : dflt_clr;
    ifdr_clr  = redirect_take ? 1'b1 : dflt_clr;
    drex_clr  = redirect_take ? 1'b1 : dflt_clr;
    pc_sel    = redirect_take;
  end
endmodule

// File: rtl/hz_ctrl_unit.sv
module hz_ctrl_unit
  import hz_pkg::*;
#(
  parameter int REG_ADDR_W = 5,
  parameter int DATA_W     = 32
) (
  input  logic [REG_ADDR_W-1:0] ex_src0_reg,
  input  logic [REG_ADDR_W-1:0] ex_src1_reg,
  input  logic [DATA_W-1:0]     ex_src0_rf,
  input  logic [DATA_W-1:0]     ex_src1_rf,
  input  logic [REG_ADDR_W-1:0] mem_dst_reg,
  input  logic                  mem_wr,
  input  logic                  mem_is_load,
  input  logic [DATA_W-1:0]     mem_alu_res,
  input  logic [REG_ADDR_W-1:0] wb_dst_reg,
  input  logic                  wb_wr,
  input  logic [DATA_W-1:0]     wb_data,
  input  logic                  ex_redirect,
  input  logic                  dflt_en,
  input  logic                  dflt_clr,
  output logic [1:0]            fwd_sel0,
  output logic [1:0]            fwd_sel1,
  output logic [DATA_W-1:0]     alu_opa,
  output logic [DATA_W-1:0]     alu_opb,
  output logic                  pc_en,
  output logic                  ifdr_en,
  output logic                  drex_en,
  output logic                  ifdr_clr,
  output logic                  drex_clr,
  output logic                  exmem_clr,
  output logic                  pc_sel
);
  localparam int NUM_SRC = 2;

  logic [NUM_SRC-1:0][REG_ADDR_W-1:0] src_regs;
  logic [NUM_SRC-1:0][DATA_W-1:0]     rf_vals;
  logic [NUM_SRC-1:0][DATA_W-1:0]     ops;
  fwd_sel_e                           sels [NUM_SRC];
  logic                               stall;

  assign src_regs = {ex_src1_reg, ex_src0_reg};
  assign rf_vals  = {ex_src1_rf,  ex_src0_rf};

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_operand
    hz_fwd_select #(.REG_ADDR_W(REG_ADDR_W)) u_sel (
      .src_reg     (src_regs[g]),
      .mem_dst_reg (mem_dst_reg),
      .mem_wr      (mem_wr),
      .wb_dst_reg  (wb_dst_reg),
      .wb_wr       (wb_wr),
      .sel         (sels[g])
    );
    hz_operand_mux #(.DATA_W(DATA_W)) u_mux (
      .sel     (sels[g]),
      .rf_val  (rf_vals[g]),
      .mem_val (mem_alu_res),
      .wb_val  (wb_data),
      .op      (ops[g])
    );
  end

  assign fwd_sel0 = sels[0];
  assign fwd_sel1 = sels[1];
  assign alu_opa  = ops[0];
  assign alu_opb  = ops[1];

  hz_load_stall #(.REG_ADDR_W(REG_ADDR_W), .NUM_SRC(NUM_SRC)) u_stall (
    .src_regs    (src_regs),
    .mem_dst_reg (mem_dst_reg),
    .mem_wr      (mem_wr),
    .mem_is_load (mem_is_load),
    .stall       (stall)
  );

  hz_flow_ctrl u_flow (
    .stall        (stall),
    .redirect_req (ex_redirect),
    .dflt_en      (dflt_en),
    .dflt_clr     (dflt_clr),
    .pc_en        (pc_en),
    .ifdr_en      (ifdr_en),
    .drex_en      (drex_en),
    .ifdr_clr     (ifdr_clr),
    .drex_clr     (drex_clr),
    .exmem_clr    (exmem_clr),
    .pc_sel       (pc_sel)
  );
endmodule

// File: rtl/hz_ctrl_checker.sv
module hz_ctrl_checker #(
  parameter int REG_ADDR_W = 5,
  parameter int DATA_W     = 32
) (
  input logic [REG_ADDR_W-1:0] ex_src0_reg,
  input logic [DATA_W-1:0]     mem_alu_res,
  input logic [DATA_W-1:0]     wb_data,
  input logic [DATA_W-1:0]     ex_src0_rf,
  input logic                  ex_redirect,
  input logic [1:0]            fwd_sel0,
  input logic [1:0]            fwd_sel1,
  input logic [DATA_W-1:0]     alu_opa,
  input logic                  pc_en,
  input logic                  ifdr_en,
  input logic                  drex_en,
  input logic                  ifdr_clr,
  input logic                  drex_clr,
  input logic                  exmem_clr,
  input logic                  pc_sel
);
  logic known;
  assign known = !$isunknown({ex_src0_reg, mem_alu_res, wb_data, ex_src0_rf, ex_redirect,
                              fwd_sel0, fwd_sel1, alu_opa, pc_en, ifdr_en, drex_en,
                              ifdr_clr, drex_clr, exmem_clr, pc_sel});

  always_comb begin
    if (known) begin
      p_sel_legal_r1: assert final (fwd_sel0 != 2'd3 && fwd_sel1 != 2'd3)
        else $error("operand select code 3");
      p_opa_source_r1: assert final ((fwd_sel0 == 2'd2) ? (alu_opa == mem_alu_res) :
                                     (fwd_sel0 == 2'd1) ? (alu_opa == wb_data) :
                                                          (alu_opa == ex_src0_rf))
        else $error("operand A differs from its selected source");
      p_zero_reg_r6: assert final (ex_src0_reg != '0 || fwd_sel0 == 2'd0)
        else $error("register 0 forwarded");
      p_stall_freeze_r8: assert final (drex_en || (!pc_en && !ifdr_en && exmem_clr))
        else $error("stall without full freeze and bubble");
      p_flush_pair_r10: assert final (!pc_sel || (ifdr_clr && drex_clr && ex_redirect))
        else $error("redirect without both flushes");
      p_redirect_held_r12: assert final (!pc_sel || drex_en)
        else $error("redirect taken during stall");
    end
  end
endmodule

bind hz_ctrl_unit hz_ctrl_checker #(.REG_ADDR_W(REG_ADDR_W), .DATA_W(DATA_W)) u_hz_chk (
  .ex_src0_reg (ex_src0_reg),
  .mem_alu_res (mem_alu_res),
  .wb_data     (wb_data),
  .ex_src0_rf  (ex_src0_rf),
  .ex_redirect (ex_redirect),
  .fwd_sel0    (fwd_sel0),
  .fwd_sel1    (fwd_sel1),
  .alu_opa     (alu_opa),
  .pc_en       (pc_en),
  .ifdr_en     (ifdr_en),
  .drex_en     (drex_en),
  .ifdr_clr    (ifdr_clr),
  .drex_clr    (drex_clr),
  .exmem_clr   (exmem_clr),
  .pc_sel      (pc_sel)
);

// File: tb/hz_ctrl_unit_bench.sv
module hz_ctrl_unit_bench;
  localparam int RW = 5;
  localparam int DW = 32;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [RW-1:0] s0, s1, mdst, wdst;
  logic [DW-1:0] rf0, rf1, mres, wdat;
  logic mwr, mld, wwr, redir, den, dclr;
  logic [1:0] sel0, sel1;
  logic [DW-1:0] opa, opb;
  logic pc_en, ifdr_en, drex_en, ifdr_clr, drex_clr, exmem_clr, pc_sel;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  hz_ctrl_unit #(.REG_ADDR_W(RW), .DATA_W(DW)) u_hz_ctrl_unit (
    .ex_src0_reg(s0), .ex_src1_reg(s1), .ex_src0_rf(rf0), .ex_src1_rf(rf1),
    .mem_dst_reg(mdst), .mem_wr(mwr), .mem_is_load(mld), .mem_alu_res(mres),
    .wb_dst_reg(wdst), .wb_wr(wwr), .wb_data(wdat), .ex_redirect(redir),
    .dflt_en(den), .dflt_clr(dclr), .fwd_sel0(sel0), .fwd_sel1(sel1),
    .alu_opa(opa), .alu_opb(opb), .pc_en(pc_en), .ifdr_en(ifdr_en),
    .drex_en(drex_en), .ifdr_clr(ifdr_clr), .drex_clr(drex_clr),
    .exmem_clr(exmem_clr), .pc_sel(pc_sel)
  );

  task automatic chk(input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // empty pipeline: bubbles everywhere, defaults enable/no clear
  task automatic idle();
    @(posedge clk);
    s0 = '0; s1 = '0; mdst = '0; wdst = '0;
    rf0 = 32'h1111; rf1 = 32'h2222; mres = 32'hAAAA; wdat = 32'hBBBB;
    mwr = 0; mld = 0; wwr = 0; redir = 0; den = 1; dclr = 0;
  endtask

  task automatic t_reset_state();
    idle(); @(negedge clk);
    chk("R5", "idle sel0", sel0, 0);
    chk("R5", "idle opa", opa, 32'h1111);
    chk("R9", "idle pc_en", pc_en, 1);
    chk("R9", "idle ifdr_en", ifdr_en, 1);
    chk("R11", "idle pc_sel", pc_sel, 0);
    chk("R11", "idle drex_clr", drex_clr, 0);
  endtask

  // addi x7 then add x8,x7,x7: producer in EX/MEM when consumer in EX
  task automatic t_back_to_back();
    idle(); s0 = 7; s1 = 7; mdst = 7; mwr = 1; mres = 32'd3;
    @(negedge clk);
    chk("R2", "b2b sel0", sel0, 2);
    chk("R1", "b2b opa", opa, 3);
    chk("R9", "b2b no stall for alu producer", drex_en, 1);
    // next cycle producer in MEM/WB, unrelated new consumer in EX
    idle(); s0 = 7; wdst = 7; wwr = 1; wdat = 32'd3;
    @(negedge clk);
    chk("R3", "wb sel0", sel0, 1);
    chk("R1", "wb opa", opa, 3);
  endtask

  task automatic t_priority();
    idle(); s0 = 10; s1 = 10;
    wdst = 10; wwr = 1; wdat = 32'd3;
    mdst = 10; mwr = 1; mres = 32'd4;
    @(negedge clk);
    chk("R4", "priority sel0", sel0, 2);
    chk("R4", "priority sum", opa + opb, 8);
  endtask

  task automatic t_no_match();
    idle(); s0 = 12; s1 = 13; mdst = 12; mwr = 0; wdst = 13; wwr = 0;
    @(negedge clk);
    chk("R5", "write flag off sel0", sel0, 0);
    chk("R5", "write flag off opb", opb, 32'h2222);
    idle(); s0 = 0; mdst = 0; mwr = 1; wdst = 0; wwr = 1;
    @(negedge clk);
    chk("R6", "zero reg sel0", sel0, 0);
    chk("R6", "zero reg opa", opa, 32'h1111);
    mld = 1; @(negedge clk);
    chk("R6", "zero reg load no stall", drex_en, 1);
  endtask

  task automatic t_independent();
    idle(); s0 = 31; s1 = 4; mdst = 4; mwr = 1; mres = 32'h44;
    wdst = 31; wwr = 1; wdat = 32'h31;
    @(negedge clk);
    chk("R7", "indep sel0", sel0, 1);
    chk("R7", "indep sel1", sel1, 2);
    chk("R7", "indep opa", opa, 32'h31);
    chk("R7", "indep opb", opb, 32'h44);
  endtask

  // ld x9 then addi x5,x9: count stall cycles while advancing the pipe
  task automatic t_load_use();
    int stalls = 0;
    idle(); s0 = 9; mdst = 9; mwr = 1; mld = 1; mres = 32'hDEAD;
    @(negedge clk);
    chk("R8", "load stall pc_en", pc_en, 0);
    chk("R8", "load stall ifdr_en", ifdr_en, 0);
    chk("R8", "load stall exmem_clr", exmem_clr, 1);
    if (!drex_en) stalls++;
    // load moves to MEM/WB, bubble in EX/MEM, consumer held in DR/EX
    @(posedge clk); mwr = 0; mld = 0; mdst = 0;
    wdst = 9; wwr = 1; wdat = 32'h5A5A;
    @(negedge clk);
    if (!drex_en) stalls++;
    chk("R8", "after stall sel0", sel0, 1);
    chk("R8", "after stall opa", opa, 32'h5A5A);
    chk("R8", "stall cycles", stalls, 1);
    idle(); s1 = 6; mdst = 6; mwr = 1; mld = 1;
    @(negedge clk);
    chk("R8", "load on src B stalls", drex_en, 0);
    s1 = 3; @(negedge clk);
    chk("R9", "load unrelated no stall", drex_en, 1);
  endtask

  task automatic t_defaults();
    idle(); den = 0; dclr = 1;
    @(negedge clk);
    chk("R9", "dflt pc_en", pc_en, 0);
    chk("R9", "dflt exmem_clr", exmem_clr, 1);
    chk("R9", "dflt drex_en", drex_en, 1);
    chk("R11", "dflt ifdr_clr", ifdr_clr, 1);
  endtask

  // jal in EX: two wrong-path slots flushed, then pipe resumes
  task automatic t_jump();
    int flushed = 0;
    idle(); redir = 1;
    @(negedge clk);
    chk("R10", "jump pc_sel", pc_sel, 1);
    flushed = int'(ifdr_clr) + int'(drex_clr);
    chk("R10", "jump flushed slots", flushed, 2);
    idle();
    @(negedge clk);
    chk("R11", "after jump pc_sel", pc_sel, 0);
    chk("R11", "after jump drex_clr", drex_clr, 0);
  endtask

  task automatic t_stall_blocks_redirect();
    idle(); s0 = 11; mdst = 11; mwr = 1; mld = 1; redir = 1;
    @(negedge clk);
    chk("R12", "stall redirect pc_sel", pc_sel, 0);
    chk("R12", "stall redirect drex_clr", drex_clr, 0);
    chk("R12", "stall redirect ifdr_clr", ifdr_clr, 0);
    chk("R8", "stall redirect still freezes", drex_en, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_back_to_back();
    t_priority();
    t_no_match();
    t_independent();
    t_load_use();
    t_defaults();
    t_jump();
    t_stall_blocks_redirect();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule